// File: doc/BRIEF.md
# Pipelined DES Round-Key Generator

This block derives the sixteen 48-bit DES round keys from a 64-bit key, one stage per round, so that each stage can sit beside the matching round of a pipelined cipher datapath. A key enters with a valid flag and a direction flag. Parity bits are dropped, the remaining 56 bits are split into two 28-bit halves, and each stage rotates both halves and registers them. A stage's round key is the 48-bit compression of its registered halves. A new key may be accepted every clock cycle, and every stage carries its own valid and direction flags.

For decryption the halves rotate right instead of left. The first stage applies no rotation. The key sequence therefore comes out in reverse order, and nothing has to be stored and replayed.

Top module: `des_keysched_pipe`

## Requirements
- R1: Key bits 0, 8, 16, 24, 32, 40, 48 and 56 (bit 0 is the least significant bit of `in_key`, i.e. the lowest bit of every byte) are parity bits and have no effect on any round key.
- R2: The 56 kept bits follow the standard permuted choice 1, which forms the C and D halves. Each round key is the standard permuted choice 2 of the concatenated halves {C,D}. Bit 1 of each standard table is the most significant bit of its vector.
- R3: With `in_dec`=0, stage s (s = 0..15) rotates both halves left by 1 for rounds 1, 2, 9 and 16, and by 2 for all other rounds. Round number = s+1.
- R4: With `in_dec`=1, stage 0 does not rotate. Stages for rounds 2, 9 and 16 rotate both halves right by 1, and the remaining stages rotate right by 2.
- R5: For any key, the decrypt round key of round r equals the encrypt round key of round 17-r.
- R6: Rotations are circular within each 28-bit half, so the number of set bits in each half stays the same from stage to stage.
- R7: A key captured at a clock edge with `in_vld`=1 appears at stage s, with `stage_vld[s]`=1 and its direction on `stage_dec[s]`, s+1 edges later. A new key may be accepted on every edge. Reset clears all `stage_vld` bits.
- R8: Key 0x133457799BBCDFF1 gives encrypt round-1 key 0x1B02EFFC7072 and round-16 key 0xCB3D8B0E17F5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset, clears stage valids |
| in_vld | input | 1 | A key is presented this cycle |
| in_dec | input | 1 | 1 = decrypt order (right rotation), 0 = encrypt order |
| in_key | input | 64 | 64-bit key including parity bits |
| stage_vld | output | 16 | Per-stage valid, bit s for round s+1 |
| stage_dec | output | 16 | Per-stage direction flag |
| stage_key | output | 768 | Round keys, 48 bits per stage, stage s at bits [48*s+47:48*s] |

## Verification
The assertions assume that reset is held low from time zero until the first edges have passed. They also assume `in_key` and `in_dec` are known whenever `in_vld` is high, because the halves from PC-1 are compared with the first stage and the set-bit counts are compared between neighbouring stages. The stimulus drives a known key and direction on every cycle, including cycles where `in_vld` is low. It changes inputs only on the falling edge, so every captured value is settled. Random keys, directions and valid gaps are mixed with the known vector, all-zero and all-one keys, and keys with flipped parity bits.

// File: rtl/des_ks_pkg.sv
package des_ks_pkg;
   localparam int KS_KEY_W   = 64;
   localparam int KS_HALF_W  = 28;
   localparam int KS_CD_W    = 56;
   localparam int KS_RK_W    = 48;
   localparam int KS_NROUNDS = 16;

   // R2: standard permuted choice 1 (1-based, bit 1 = MSB of key)
   localparam int PC1_SEL [KS_CD_W] = '{
      57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
      10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
      63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
      14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4};

   // R2: standard permuted choice 2 (1-based, bit 1 = MSB of {C,D})
   localparam int PC2_SEL [KS_RK_W] = '{
      14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
      23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
      41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
      44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};

   // R3/R4: rotation distance for a 1-based round number
   function automatic int ks_rot_amt(input int round, input bit dec);
      bit single;
      single = (round == 1) || (round == 2) || (round == 9) || (round == 16);
      if (dec) begin
         if (round == 1) return 0;
         return ((round == 2) || (round == 9) || (round == 16)) ? 1 : 2;
      end
      return single ? 1 : 2;
   endfunction
endpackage

// File: rtl/des_ks_pc1.sv
module des_ks_pc1 #(
   parameter int KEY_W = des_ks_pkg::KS_KEY_W,
   parameter int CD_W  = des_ks_pkg::KS_CD_W
) (
   input  logic [KEY_W-1:0] key,
   output logic [CD_W-1:0]  cd
);
   for (genvar i = 0; i < CD_W; i++) begin : g_sel
      assign cd[CD_W-1-i] = key[KEY_W - des_ks_pkg::PC1_SEL[i]];
   end
endmodule

// File: rtl/des_ks_pc2.sv
module des_ks_pc2 #(
   parameter int CD_W = des_ks_pkg::KS_CD_W,
   parameter int RK_W = des_ks_pkg::KS_RK_W
) (
   input  logic [CD_W-1:0] cd,
   output logic [RK_W-1:0] rk
);
   for (genvar i = 0; i < RK_W; i++) begin : g_sel
      assign rk[RK_W-1-i] = cd[CD_W - des_ks_pkg::PC2_SEL[i]];
   end
endmodule

// File: rtl/des_ks_stage.sv
module des_ks_stage #(
   parameter int ROUND  = 1,
   parameter int HALF_W = des_ks_pkg::KS_HALF_W,
   parameter int RK_W   = des_ks_pkg::KS_RK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld_in,
   input  logic              dec_in,
   input  logic [HALF_W-1:0] c_in,
   input  logic [HALF_W-1:0] d_in,
   output logic              vld_q,
   output logic              dec_q,
   output logic [HALF_W-1:0] c_q,
   output logic [HALF_W-1:0] d_q,
   output logic [RK_W-1:0]   rk
);
   localparam int SH_L = des_ks_pkg::ks_rot_amt(ROUND, 1'b0);
   localparam int SH_R = des_ks_pkg::ks_rot_amt(ROUND, 1'b1);

   logic [HALF_W-1:0] c_rot, d_rot;

   if (SH_R == 0) begin : g_dec_hold
      // R4: first decrypt round keeps the halves as they are
      assign c_rot = dec_in ? c_in : ((c_in << SH_L) | (c_in >> (HALF_W - SH_L)));
      assign d_rot = dec_in ? d_in : ((d_in << SH_L) | (d_in >> (HALF_W - SH_L)));
   end else begin : g_dec_rot
      assign c_rot = dec_in ? ((c_in >> SH_R) | (c_in << (HALF_W - SH_R)))
                            : ((c_in << SH_L) | (c_in >> (HALF_W - SH_L)));
      assign d_rot = dec_in ? ((d_in >> SH_R) | (d_in << (HALF_W - SH_R)))
                            : ((d_in << SH_L) | (d_in >> (HALF_W - SH_L)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else        vld_q <= vld_in;
   end

   always_ff @(posedge clk) begin
      dec_q <= dec_in;
      c_q   <= c_rot;
      d_q   <= d_rot;
   end

   des_ks_pc2 #(.CD_W(2*HALF_W), .RK_W(RK_W)) u_pc2 (
      .cd ({c_q, d_q}),
      .rk (rk)
   );
endmodule

// File: rtl/des_keysched_pipe.sv
module des_keysched_pipe #(
   parameter int KEY_W   = des_ks_pkg::KS_KEY_W,
   parameter int HALF_W  = des_ks_pkg::KS_HALF_W,
   parameter int RK_W    = des_ks_pkg::KS_RK_W,
   parameter int NROUNDS = des_ks_pkg::KS_NROUNDS
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_vld,
   input  logic                    in_dec,
   input  logic [KEY_W-1:0]        in_key,
   output logic [NROUNDS-1:0]      stage_vld,
   output logic [NROUNDS-1:0]      stage_dec,
   output logic [NROUNDS*RK_W-1:0] stage_key
);
   localparam int CD_W = 2 * HALF_W;

   if (KEY_W != 64 || CD_W != 56 || RK_W != 48 || NROUNDS != 16) begin : g_bad_cfg
      $error("des_keysched_pipe: the DES tables fix 64/28/48/16");
   end

   logic [CD_W-1:0]   pc1_cd;
   logic [HALF_W-1:0] c_q [NROUNDS];
   logic [HALF_W-1:0] d_q [NROUNDS];

   des_ks_pc1 #(.KEY_W(KEY_W), .CD_W(CD_W)) u_pc1 (
      .key (in_key),
      .cd  (pc1_cd)
   );

   for (genvar s = 0; s < NROUNDS; s++) begin : g_stage
      logic              v_in, m_in;
      logic [HALF_W-1:0] c_in, d_in;
      if (s == 0) begin : g_head
         assign v_in = in_vld;
         assign m_in = in_dec;
         assign c_in = pc1_cd[CD_W-1:HALF_W];
         assign d_in = pc1_cd[HALF_W-1:0];
      end else begin : g_link
         assign v_in = stage_vld[s-1];
         assign m_in = stage_dec[s-1];
         assign c_in = c_q[s-1];
         assign d_in = d_q[s-1];

         // R7: valid advances one stage per edge
         a_r7_vld_shift: assert property (@(posedge clk) disable iff (!rst_n)
            stage_vld[s] == $past(stage_vld[s-1]));
         // R7: direction travels with the key
         a_r7_dec_follow: assert property (@(posedge clk) disable iff (!rst_n)
            stage_vld[s] |-> stage_dec[s] == $past(stage_dec[s-1]));
         // R6: rotation keeps the set-bit count of each half
         a_r6_c_popcnt: assert property (@(posedge clk) disable iff (!rst_n)
            stage_vld[s] |-> $countones(c_q[s]) == $past($countones(c_q[s-1])));
         a_r6_d_popcnt: assert property (@(posedge clk) disable iff (!rst_n)
            stage_vld[s] |-> $countones(d_q[s]) == $past($countones(d_q[s-1])));
      end

      des_ks_stage #(.ROUND(s+1), .HALF_W(HALF_W), .RK_W(RK_W)) u_stage (
         .clk    (clk),
         .rst_n  (rst_n),
         .vld_in (v_in),
         .dec_in (m_in),
         .c_in   (c_in),
         .d_in   (d_in),
         .vld_q  (stage_vld[s]),
         .dec_q  (stage_dec[s]),
         .c_q    (c_q[s]),
         .d_q    (d_q[s]),
         .rk     (stage_key[s*RK_W +: RK_W])
      );
   end

   // R4: first decrypt stage holds the unrotated PC-1 halves
   a_r4_dec_first: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_vld[0] && stage_dec[0]) |-> {c_q[0], d_q[0]} == $past(pc1_cd));
   // R3: first encrypt stage is the PC-1 halves turned left by one
   a_r3_enc_first: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_vld[0] && !stage_dec[0]) |->
         {c_q[0], d_q[0]} == {$past(pc1_cd[CD_W-2:HALF_W]), $past(pc1_cd[CD_W-1]),
                              $past(pc1_cd[HALF_W-2:0]),    $past(pc1_cd[HALF_W-1])});
endmodule

// File: tb/des_keysched_pipe_bench.sv
module des_keysched_pipe_bench;
   localparam int NR  = 16;
   localparam int LEN = 400;

   localparam int T_PC1 [56] = '{
      57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
      10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
      63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
      14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4};
   localparam int T_PC2 [48] = '{
      14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
      23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
      41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
      44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};
   localparam logic [63:0] PARITY = 64'h0101010101010101;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_vld = 1'b0;
   logic          in_dec = 1'b0;
   logic [63:0]   in_key = '0;
   logic [NR-1:0] stage_vld, stage_dec;
   logic [NR*48-1:0] stage_key;

   int errors = 0;
   int checks = 0;

   logic [63:0] h_key [LEN+1];
   logic        h_vld [LEN+1];
   logic        h_dec [LEN+1];

   always #4 clk = ~clk;

   des_keysched_pipe u_des_keysched_pipe (
      .clk (clk), .rst_n (rst_n), .in_vld (in_vld), .in_dec (in_dec),
      .in_key (in_key), .stage_vld (stage_vld), .stage_dec (stage_dec),
      .stage_key (stage_key));

   // Encrypt keys by cumulative left turns; decrypt keys as the reversed list (R5)
   function automatic logic [47:0] ref_key(input logic [63:0] k, input int round, input bit dec);
      logic [55:0] cd;
      logic [27:0] c, d;
      logic [47:0] rk;
      int          r_eff;
      r_eff = dec ? (17 - round) : round;
      for (int i = 0; i < 56; i++) cd[55-i] = k[64 - T_PC1[i]];
      c = cd[55:28];
      d = cd[27:0];
      for (int r = 1; r <= r_eff; r++) begin
         int n;
         n = (r == 1 || r == 2 || r == 9 || r == 16) ? 1 : 2;
         for (int j = 0; j < n; j++) begin
            c = {c[26:0], c[27]};
            d = {d[26:0], d[27]};
         end
      end
      cd = {c, d};
      for (int i = 0; i < 48; i++) rk[47-i] = cd[56 - T_PC2[i]];
      return rk;
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20250));
      // directed head of the stream, then random
      for (int m = 1; m <= LEN; m++) begin
         h_vld[m] = ($urandom % 5) != 0;
         h_dec[m] = $urandom % 2;
         h_key[m] = {$urandom, $urandom};
      end
      h_key[1] = 64'h133457799BBCDFF1; h_dec[1] = 1'b0; h_vld[1] = 1'b1;
      h_key[2] = 64'h133457799BBCDFF1; h_dec[2] = 1'b1; h_vld[2] = 1'b1;
      h_key[3] = 64'h0;                h_dec[3] = 1'b0; h_vld[3] = 1'b1;
      h_key[4] = '1;                   h_dec[4] = 1'b1; h_vld[4] = 1'b1;
      h_key[5] = 64'h133457799BBCDFF1 ^ PARITY; h_dec[5] = 1'b0; h_vld[5] = 1'b1;
      h_key[6] = 64'h0 ^ PARITY;       h_dec[6] = 1'b1; h_vld[6] = 1'b1;
      h_vld[7] = 1'b0;

      // R7: valids clear under reset even with input valid
      in_vld = 1'b1;
      repeat (3) @(negedge clk);
      check(stage_vld == '0, "R7 reset valid", 64'(stage_vld), 64'h0);
      in_vld = 1'b0;
      rst_n = 1'b1;

      for (int m = 1; m <= LEN + NR + 2; m++) begin
         @(negedge clk);
         for (int s = 0; s < NR; s++) begin
            int idx;
            idx = m - s - 1;
            if (idx >= 1 && idx <= LEN) begin
               check(stage_vld[s] == h_vld[idx], "R7 valid", 64'(stage_vld[s]), 64'(h_vld[idx]));
               if (h_vld[idx]) begin
                  logic [47:0] exp;
                  check(stage_dec[s] == h_dec[idx], "R7 dir", 64'(stage_dec[s]), 64'(h_dec[idx]));
                  // R1: expected uses the key with parity bits cleared
                  exp = ref_key(h_key[idx] & ~PARITY, s + 1, h_dec[idx]);
                  check(stage_key[s*48 +: 48] == exp,
                        h_dec[idx] ? "R4 R5 R1 R2 dec key" : "R3 R1 R2 enc key",
                        64'(stage_key[s*48 +: 48]), 64'(exp));
                  if (idx == 1 && s == 0)
                     check(stage_key[47:0] == 48'h1B02EFFC7072, "R8 enc round1",
                           64'(stage_key[47:0]), 64'h1B02EFFC7072);
                  if (idx == 1 && s == 15)
                     check(stage_key[15*48 +: 48] == 48'hCB3D8B0E17F5, "R8 enc round16",
                           64'(stage_key[15*48 +: 48]), 64'hCB3D8B0E17F5);
                  if (idx == 2 && s == 0)
                     check(stage_key[47:0] == 48'hCB3D8B0E17F5, "R5 dec round1",
                           64'(stage_key[47:0]), 64'hCB3D8B0E17F5);
                  if (idx == 5 && s == 3)
                     check(stage_key[3*48 +: 48] == ref_key(64'h133457799BBCDFF1, 4, 1'b0),
                           "R1 parity flip", 64'(stage_key[3*48 +: 48]),
                           64'(ref_key(64'h133457799BBCDFF1, 4, 1'b0)));
               end
            end
         end
         if (m <= LEN) begin
            in_vld = h_vld[m];
            in_dec = h_dec[m];
            in_key = h_key[m];
         end else begin
            in_vld = 1'b0;
         end
      end
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule